// File: doc/BRIEF.md
# Precision-Reconfigurable Multiply-Accumulate Array

This block is the arithmetic core of a convolution processing element whose operand precision is chosen per layer. Four 4-bit by 4-bit signed/unsigned multiplier units are steered at run time into one of four arrangements. The arrangements give four independent 4x4 products, two 4x8 products, two 8x4 products or a single 8x8 product per beat. Each product lane feeds its own running accumulator. Narrow operands arrive two per byte, so a 16-bit weight bus and a 16-bit activation bus stay fully used in every mode.

A window starts with a beat that carries `in_start`. That beat loads the accumulators instead of adding to them, and it also latches the precision configuration for the whole window. Every following valid beat adds its products. Accumulator values appear two clock edges after the beat that produced them, together with a one-cycle `out_valid`.

Top module: `pmac_array`

## Requirements
- R1: With `cfg_wgt8`=0 and `cfg_act8`=0, lane k (k=0..3) receives the signed product of weight nibble k (`wgt_bus[4k+3:4k]`) and activation nibble k (`act_bus[4k+3:4k]`).
- R2: With `cfg_wgt8`=0 and `cfg_act8`=1, lane k (k=0,1) receives signed weight nibble k times signed activation byte k (`act_bus[8k+7:8k]`). Lanes 2 and 3 receive zero.
- R3: With `cfg_wgt8`=1 and `cfg_act8`=0, lane k (k=0,1) receives signed weight byte k (`wgt_bus[8k+7:8k]`) times signed activation nibble k. Lanes 2 and 3 receive zero.
- R4: With both widths 8, lane 0 receives signed weight byte 0 times signed activation byte 0. Lanes 1 to 3 receive zero, and the upper bus bytes have no effect.
- R5: All operands are two's complement, and results are exact at the range ends, e.g. (-128)x(-128) = 16384 and (-8)x(-8) = 64.
- R6: A valid beat with `in_start`=1 loads each accumulator with that beat's lane product. Valid beats without start add their lane product to the accumulator.
- R7: Accumulator lane k is `acc_bus[22k+21:22k]`, signed. It holds the exact sum of 64 worst-case 8x8 products (+1048576 and -1040384).
- R8: The precision configuration is captured only on a valid start beat. Configuration changes between start beats do not alter how later beats are multiplied.
- R9: `out_valid` is high for exactly one cycle, two rising edges after each valid input beat. Accumulators update at that same edge.
- R10: Synchronous active-high reset clears `out_valid` and all accumulators.
- R11: Beats with `in_valid`=0 leave every accumulator unchanged, whatever the data, start and configuration inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input beat valid |
| in_start | input | 1 | First beat of an accumulation window |
| cfg_wgt8 | input | 1 | 1 = 8-bit weights, 0 = packed 4-bit weights |
| cfg_act8 | input | 1 | 1 = 8-bit activations, 0 = packed 4-bit activations |
| wgt_bus | input | 16 | Weight operands (four nibbles or two bytes) |
| act_bus | input | 16 | Activation operands (four nibbles or two bytes) |
| out_valid | output | 1 | Accumulators reflect a new beat |
| acc_bus | output | 88 | Four 22-bit signed lane accumulators |

## Verification
The hardest situation to reach from the ports is a full 64-beat window of extreme products. Only there can the accumulator's headroom and the sign handling of the composed 8x8 product fail together. The bench streams 64 back-to-back (-128)x(-128) beats and then 64 beats of 127x(-128), and compares the exact totals. A second hard case is a configuration change in mid-window. The bench reaches it by flipping both width inputs after a start beat and feeding data whose result differs between the two interpretations.

// File: rtl/pmac_pkg.sv
package pmac_pkg;
    localparam int NIB_W   = 4;
    localparam int UNITS   = 4;
    localparam int BYTE_W  = 2 * NIB_W;
    localparam int BUS_W   = UNITS * NIB_W;
    localparam int UPROD_W = 2 * (NIB_W + 1);
    localparam int PROD_W  = 2 * BYTE_W;

    // encoding is {weight is 8-bit, activation is 8-bit}
    typedef enum logic [1:0] {
        PM_4X4  = 2'b00,
        PM_W4A8 = 2'b01,
        PM_W8A4 = 2'b10,
        PM_8X8  = 2'b11
    } prec_mode_e;

    typedef logic signed [UPROD_W-1:0] uprod_t;
    typedef logic signed [PROD_W-1:0]  lprod_t;

    // how one 4x4 unit is fed and where its partial product goes
    typedef struct packed {
        logic [1:0] w_idx;
        logic       w_sgn;
        logic [1:0] a_idx;
        logic       a_sgn;
        logic [1:0] lane;
        logic [3:0] shift;
    } route_t;

    function automatic route_t unit_route(prec_mode_e m, logic [1:0] u);
        route_t r;
        case (m)
            PM_4X4: begin
                r.w_idx = u;         r.w_sgn = 1'b1;
                r.a_idx = u;         r.a_sgn = 1'b1;
                r.lane  = u;         r.shift = 4'd0;
            end
            PM_W4A8: begin
                r.w_idx = u >> 1;    r.w_sgn = 1'b1;
                r.a_idx = u;         r.a_sgn = u[0];
                r.lane  = u >> 1;    r.shift = u[0] ? 4'd4 : 4'd0;
            end
            PM_W8A4: begin
                r.w_idx = u;         r.w_sgn = u[0];
                r.a_idx = u >> 1;    r.a_sgn = 1'b1;
                r.lane  = u >> 1;    r.shift = u[0] ? 4'd4 : 4'd0;
            end
            default: begin
                r.w_idx = {1'b0, u[0]}; r.w_sgn = u[0];
                r.a_idx = {1'b0, u[1]}; r.a_sgn = u[1];
                r.lane  = 2'd0;
                r.shift = {u[0] & u[1], u[0] ^ u[1], 2'b00};
            end
        endcase
        return r;
    endfunction
endpackage

// File: rtl/pmac_nib_mult.sv
module pmac_nib_mult
    import pmac_pkg::*;
(
    input  logic [NIB_W-1:0] w_nib,
    input  logic             w_sgn,
    input  logic [NIB_W-1:0] a_nib,
    input  logic             a_sgn,
    output uprod_t           prod
);
    // a high nibble is signed, a low nibble unsigned: extend to 5 bits
    logic signed [NIB_W:0] w_ext, a_ext;

    assign w_ext = {w_sgn & w_nib[NIB_W-1], w_nib};
    assign a_ext = {a_sgn & a_nib[NIB_W-1], a_nib};
    assign prod  = w_ext * a_ext;
endmodule

// File: rtl/pmac_compose.sv
module pmac_compose
    import pmac_pkg::*;
(
    input  prec_mode_e mode,
    input  uprod_t     prods [UNITS],
    output lprod_t     lanes [UNITS]
);
    always_comb begin
        route_t r;
        lprod_t ext;
        for (int k = 0; k < UNITS; k++) lanes[k] = '0;
        for (int u = 0; u < UNITS; u++) begin
            r   = unit_route(mode, 2'(u));
            ext = lprod_t'(prods[u]);
            lanes[r.lane] = lanes[r.lane] + (ext <<< r.shift);
        end
    end
endmodule

// File: rtl/pmac_lane_acc.sv
module pmac_lane_acc
    import pmac_pkg::*;
#(
    parameter int ACC_W = 22
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    en,
    input  logic                    load,
    input  lprod_t                  lane_prod,
    output logic signed [ACC_W-1:0] acc
);
    always_ff @(posedge clk) begin
        if (rst)       acc <= '0;
        else if (en)   acc <= load ? ACC_W'(lane_prod) : acc + ACC_W'(lane_prod);
    end

    // R11: no enable, no change
    a_r11_hold_idle: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(acc));
endmodule

// File: rtl/pmac_array.sv
module pmac_array
    import pmac_pkg::*;
#(
    parameter int ACC_DEPTH = 64
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           in_valid,
    input  logic                           in_start,
    input  logic                           cfg_wgt8,
    input  logic                           cfg_act8,
    input  logic [BUS_W-1:0]               wgt_bus,
    input  logic [BUS_W-1:0]               act_bus,
    output logic                           out_valid,
    output logic [UNITS*(PROD_W+$clog2(ACC_DEPTH))-1:0] acc_bus
);
    localparam int ACC_W = PROD_W + $clog2(ACC_DEPTH);

    prec_mode_e mode_q, mode_eff;
    logic       take_start;
    uprod_t     u_prod  [UNITS];
    uprod_t     s1_prod [UNITS];
    lprod_t     lanes   [UNITS];
    logic       s1_valid, s1_start;
    prec_mode_e s1_mode;
    logic signed [ACC_W-1:0] acc_q [UNITS];

    // configuration is taken only on a start beat
    assign take_start = in_valid && in_start;
    assign mode_eff   = take_start ? prec_mode_e'({cfg_wgt8, cfg_act8}) : mode_q;

    always_ff @(posedge clk) begin
        if (rst)             mode_q <= PM_4X4;
        else if (take_start) mode_q <= mode_eff;
    end

    // stage 1: operand steering and 4x4 units
    for (genvar u = 0; u < UNITS; u++) begin : g_unit
        route_t r;
        assign r = unit_route(mode_eff, 2'(u));
        pmac_nib_mult u_mult (
            .w_nib (wgt_bus[int'(r.w_idx)*NIB_W +: NIB_W]),
            .w_sgn (r.w_sgn),
            .a_nib (act_bus[int'(r.a_idx)*NIB_W +: NIB_W]),
            .a_sgn (r.a_sgn),
            .prod  (u_prod[u])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid <= 1'b0;
            s1_start <= 1'b0;
            s1_mode  <= PM_4X4;
            for (int u = 0; u < UNITS; u++) s1_prod[u] <= '0;
        end else begin
            s1_valid <= in_valid;
            s1_start <= take_start;
            s1_mode  <= mode_eff;
            for (int u = 0; u < UNITS; u++) s1_prod[u] <= u_prod[u];
        end
    end

    // stage 2: recombine partial products and accumulate
    pmac_compose u_compose (
        .mode  (s1_mode),
        .prods (s1_prod),
        .lanes (lanes)
    );

    for (genvar k = 0; k < UNITS; k++) begin : g_lane
        pmac_lane_acc #(.ACC_W(ACC_W)) u_acc (
            .clk       (clk),
            .rst       (rst),
            .en        (s1_valid),
            .load      (s1_start),
            .lane_prod (lanes[k]),
            .acc       (acc_q[k])
        );
        assign acc_bus[k*ACC_W +: ACC_W] = acc_q[k];
    end

    always_ff @(posedge clk) begin
        if (rst) out_valid <= 1'b0;
        else     out_valid <= s1_valid;
    end

    // R8: stored configuration moves only on a start beat
    a_r8_mode_latched: assert property (@(posedge clk) disable iff (rst)
        !take_start |=> $stable(mode_q));
    // R9: two-edge latency, one output per beat
    a_r9_stage1: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> s1_valid);
    a_r9_stage2: assert property (@(posedge clk) disable iff (rst)
        s1_valid |=> out_valid);
    a_r9_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !s1_valid |=> !out_valid);
    // R4: single-product mode leaves upper lanes at zero
    a_r4_idle_lanes: assert property (@(posedge clk) disable iff (rst)
        (s1_valid && s1_start && s1_mode == PM_8X8)
        |=> (acc_q[1] == '0 && acc_q[2] == '0 && acc_q[3] == '0));
    // R2/R3: two-product modes leave lanes 2 and 3 at zero
    a_r2_r3_idle_lanes: assert property (@(posedge clk) disable iff (rst)
        (s1_valid && s1_start && (s1_mode == PM_W4A8 || s1_mode == PM_W8A4))
        |=> (acc_q[2] == '0 && acc_q[3] == '0));
    // R5: a composed product stays inside the signed 8x8 range
    a_r5_prod_range: assert property (@(posedge clk) disable iff (rst)
        s1_valid |-> (lanes[0] <= 16'sd16384 && lanes[0] >= -16'sd16256));
    // R10: reset clears the output strobe
    a_r10_reset: assert property (@(posedge clk)
        rst |=> (!out_valid && acc_q[0] == '0));
endmodule

// File: tb/pmac_array_test.sv
`timescale 1ns/1ps
module pmac_array_test;
    localparam int AW = 22;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0, in_start = 1'b0;
    logic        cfg_wgt8 = 1'b0, cfg_act8 = 1'b0;
    logic [15:0] wgt_bus = '0, act_bus = '0;
    logic        out_valid;
    logic [4*AW-1:0] acc_bus;

    int n_chk = 0, n_bad = 0;

    always #2.5 clk = ~clk;

    pmac_array uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_start(in_start),
        .cfg_wgt8(cfg_wgt8), .cfg_act8(cfg_act8),
        .wgt_bus(wgt_bus), .act_bus(act_bus),
        .out_valid(out_valid), .acc_bus(acc_bus)
    );

    // stimulus table: {wgt8, act8, wgt_bus, act_bus}
    localparam logic [33:0] VEC [9] = '{
        {1'b0, 1'b0, 16'h87F1, 16'h8F72},   // R1, includes -8 x -8
        {1'b0, 1'b0, 16'h1234, 16'hFEDC},   // R1
        {1'b0, 1'b1, 16'hA987, 16'h807F},   // R2, upper weight byte unused
        {1'b0, 1'b1, 16'h00F8, 16'h7F80},   // R2
        {1'b1, 1'b0, 16'h807F, 16'h0087},   // R3
        {1'b1, 1'b0, 16'hC3A5, 16'hFF19},   // R3
        {1'b1, 1'b1, 16'hFF80, 16'hAA80},   // R4/R5: -128 x -128
        {1'b1, 1'b1, 16'h127F, 16'h3480},   // R4/R5: 127 x -128
        {1'b1, 1'b1, 16'h0003, 16'h00FD}    // R4: 3 x -3
    };

    function automatic int ref_lane(logic w8, logic a8, logic [15:0] w, logic [15:0] a, int k);
        logic signed [7:0] wv, av;
        int n;
        n  = (w8 && a8) ? 1 : ((w8 || a8) ? 2 : 4);
        wv = w8 ? w[8*k +: 8] : {{4{w[4*k+3]}}, w[4*k +: 4]};
        av = a8 ? a[8*k +: 8] : {{4{a[4*k+3]}}, a[4*k +: 4]};
        return (k < n) ? int'(wv) * int'(av) : 0;
    endfunction

    function automatic string mode_tag(logic w8, logic a8);
        case ({w8, a8})
            2'b00:   return "R1";
            2'b01:   return "R2";
            2'b10:   return "R3";
            default: return "R4";
        endcase
    endfunction

    function automatic int lane_of(int k);
        logic signed [AW-1:0] v;
        v = acc_bus[k*AW +: AW];
        return int'(v);
    endfunction

    task automatic chk(string tag, int got, int exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic beat(logic st, logic w8, logic a8, logic [15:0] w, logic [15:0] a);
        @(negedge clk);
        in_valid = 1'b1; in_start = st;
        cfg_wgt8 = w8;   cfg_act8 = a8;
        wgt_bus  = w;    act_bus  = a;
    endtask

    // drop valid, then wait until the last beat has reached the accumulators
    task automatic drain();
        @(negedge clk);
        in_valid = 1'b0; in_start = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int e [4];
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10: reset state
        chk("R10 out_valid", int'(out_valid), 0);
        for (int k = 0; k < 4; k++) chk("R10 acc", lane_of(k), 0);

        // table walk: one start beat per vector
        for (int i = 0; i < 9; i++) begin
            logic w8, a8; logic [15:0] w, a;
            {w8, a8, w, a} = VEC[i];
            beat(1'b1, w8, a8, w, a);
            drain();
            for (int k = 0; k < 4; k++)
                chk(mode_tag(w8, a8), lane_of(k), ref_lane(w8, a8, w, a, k));
        end

        // R5: extreme-value product
        beat(1'b1, 1'b1, 1'b1, 16'h0080, 16'h0080);
        drain();
        chk("R5 min x min", lane_of(0), 16384);

        // R4: garbage in upper bytes does not disturb the 8x8 product
        beat(1'b1, 1'b1, 1'b1, 16'h5AF9, 16'hC30B);
        drain();
        chk("R4 upper bytes ignored", lane_of(0), -7 * 11);
        chk("R4 lane1 zero", lane_of(1), 0);

        // R9: latency and single-cycle strobe
        beat(1'b1, 1'b0, 1'b0, 16'h1111, 16'h1111);
        @(negedge clk);
        in_valid = 1'b0; in_start = 1'b0;
        chk("R9 not yet valid", int'(out_valid), 0);
        @(negedge clk);
        chk("R9 valid after two edges", int'(out_valid), 1);
        @(negedge clk);
        chk("R9 strobe one cycle", int'(out_valid), 0);

        // R6: accumulation of three mixed beats, then a restart
        for (int k = 0; k < 4; k++)
            e[k] = ref_lane(0, 1, 16'h00F3, 16'h7F90, k) + ref_lane(0, 1, 16'h0085, 16'h01FF, k)
                 + ref_lane(0, 1, 16'h0077, 16'h8080, k);
        beat(1'b1, 1'b0, 1'b1, 16'h00F3, 16'h7F90);
        beat(1'b0, 1'b0, 1'b1, 16'h0085, 16'h01FF);
        beat(1'b0, 1'b0, 1'b1, 16'h0077, 16'h8080);
        drain();
        for (int k = 0; k < 4; k++) chk("R6 accumulate", lane_of(k), e[k]);
        beat(1'b1, 1'b0, 1'b1, 16'h0012, 16'h0304);
        drain();
        for (int k = 0; k < 4; k++)
            chk("R6 start reloads", lane_of(k), ref_lane(0, 1, 16'h0012, 16'h0304, k));

        // R11: invalid beats with busy inputs leave accumulators alone
        @(negedge clk);
        in_valid = 1'b0; in_start = 1'b1; cfg_wgt8 = 1'b1; cfg_act8 = 1'b1;
        wgt_bus = 16'h8080; act_bus = 16'h8080;
        repeat (4) @(negedge clk);
        in_start = 1'b0;
        for (int k = 0; k < 4; k++)
            chk("R11 idle hold", lane_of(k), ref_lane(0, 1, 16'h0012, 16'h0304, k));

        // R8: configuration flip mid-window is ignored
        beat(1'b1, 1'b0, 1'b0, 16'h1111, 16'h2222);
        beat(1'b0, 1'b1, 1'b1, 16'h1111, 16'h2222);
        drain();
        for (int k = 0; k < 4; k++) chk("R8 mode held", lane_of(k), 4);

        // R7: 64 worst-case positive products
        for (int j = 0; j < 64; j++) beat(j == 0, 1'b1, 1'b1, 16'h0080, 16'h0080);
        drain();
        chk("R7 max positive sum", lane_of(0), 1048576);
        // R7: 64 worst-case negative products
        for (int j = 0; j < 64; j++) beat(j == 0, 1'b1, 1'b1, 16'h007F, 16'h0080);
        drain();
        chk("R7 max negative sum", lane_of(0), -1040384);

        // R10: reset in mid-run clears state
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R10 reset clears acc", lane_of(0), 0);
        chk("R10 reset clears valid", int'(out_valid), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule